// File: doc/BRIEF.md
# Clock Control and Timer Prescaler

This block sets the system clock rate and the timer time base for a small microcontroller core. It runs entirely in the oscillator clock domain and holds one 8-bit control register that software writes and reads back. From that register it produces three single-domain outputs. The first is a system clock enable that pulses once every 1, 2, 4, ... 128 oscillator cycles. The second is a timer tick enable from a reloading down-counting prescaler. The third is an optional square wave at half the system clock rate.

Downstream logic clocks from the oscillator and advances only on cycles where the system clock enable is high. A new divide setting is held back until a free-running 7-bit oscillator counter wraps to zero. At that instant every power-of-two period boundary lines up, so the enable never shows a period other than the old one or the new one. The wrap comes round at most 128 oscillator cycles after the write.

Top module: `clk_ctl_top`

## Requirements
- R1: After reset the register reads 0x00, the system clock enable and the timer tick are high on every oscillator cycle, and the clock output is low.
- R2: A write stores the whole byte and it is visible on the readback port in the next cycle. The fields are: bit 0 is the clock output enable, bits 3:1 are the divide code, and bits 7:4 are the prescale value.
- R3: With divide code k (0 to 7) applied, the system clock enable is a one-cycle pulse that repeats every 2^k oscillator cycles.
- R4: A new divide code takes effect when the free-running 7-bit oscillator counter wraps to zero, which is no more than 128 oscillator cycles after the write. Until then the enable keeps the old period. No enable interval ever differs from both the old period and the new one.
- R5: With prescale value p, the timer tick is a pulse that coincides with a system clock enable and repeats every p+1 enable pulses. Value 0 gives a tick on every enable, and value 11 gives one tick every 12 enables.
- R6: Any register write reloads the prescaler from the written prescale value in that same cycle. The next tick then follows after exactly p+1 enable pulses, counting the current one.
- R7: While the clock output enable is set, the clock output toggles on every system clock enable, so each high and each low phase lasts one system clock period.
- R8: While the clock output enable is clear, the clock output is driven low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write value |
| rdData | output | 8 | Register readback |
| sysClkEn | output | 1 | System clock enable pulse |
| timerTick | output | 1 | Timer time-base enable pulse |
| clkOut | output | 1 | System clock divided by two, when enabled |

## Verification
Some properties are checked on every cycle. The oscillator counter steps by one each cycle. The applied divide code changes only on the cycle after a counter wrap. A tick never appears without an enable, and the prescaler count never rises above its field. The clock output toggles on every enable while enabled and goes low when disabled. Other behaviour can only be shown by the directed scenarios, because it is about periods measured over many cycles: the actual enable spacing for each divide code, the absence of any intermediate interval when switching between two codes, the bound of 128 cycles on when a new code applies, the prescaler ratios, and the count that follows a reload.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;

  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic prescReload;  // register written this cycle: reload prescaler
    logic divApply;     // oscillator counter wraps this cycle: adopt new divide code
  } ctlStrobes_t;

endpackage

// File: rtl/clk_ctl_ctrl.sv
module clk_ctl_ctrl
  import clk_ctl_pkg::*;
#(
  parameter int OSC_W = 7,
  parameter int DIV_W = 3,
  parameter int PSC_W = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [PSC_W+DIV_W:0]         wrData,
  output logic [PSC_W+DIV_W:0]         ctrlReg,
  output logic [OSC_W-1:0]             oscCnt,
  output logic [PSC_W-1:0]             loadPresc,
  output ctlStrobes_t                  strobes
);

  localparam int REG_W    = PSC_W + DIV_W + 1;
  localparam int PSC_LSB  = DIV_W + 1;
  localparam int NUM_CODE = 1 << DIV_W;

  // Every divide ratio must fit in one wrap of the oscillator counter.
  initial begin
    if (OSC_W < NUM_CODE - 1)
      $error("OSC_W too narrow for the largest divide code");
  end

  // Control register.
  always_ff @(posedge clk) begin
    if (!rstN)      ctrlReg <= '0;
    else if (wrEn)  ctrlReg <= wrData;
  end

  // Free-running oscillator counter; its wrap is the only safe point for divider changes.
  always_ff @(posedge clk) begin
    if (!rstN) oscCnt <= '0;
    else       oscCnt <= oscCnt + 1'b1;
  end

  assign loadPresc           = wrData[REG_W-1:PSC_LSB];
  assign strobes.prescReload = wrEn;
  assign strobes.divApply    = (oscCnt == {OSC_W{1'b1}});

  // R4
  osc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN && $past(rstN) |-> oscCnt == OSC_W'($past(oscCnt) + 1'b1));

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(ctrlReg));

endmodule

// File: rtl/clk_ctl_dp.sv
module clk_ctl_dp
  import clk_ctl_pkg::*;
#(
  parameter int OSC_W = 7,
  parameter int DIV_W = 3,
  parameter int PSC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [OSC_W-1:0]  oscCnt,
  input  logic [DIV_W-1:0]  divField,
  input  logic [PSC_W-1:0]  prescField,
  input  logic [PSC_W-1:0]  loadPresc,
  input  logic              outEnable,
  output logic              sysClkEn,
  output logic              timerTick,
  output logic              clkOut
);

  localparam int NUM_CODE = 1 << DIV_W;

  logic [DIV_W-1:0]    activeDiv;
  logic [NUM_CODE-1:0] candEn;
  logic [PSC_W-1:0]    prescCnt;
  logic                clkOutQ;

  // Applied divide code: only refreshed on the counter wrap.
  always_ff @(posedge clk) begin
    if (!rstN)                 activeDiv <= '0;
    else if (strobes.divApply) activeDiv <= divField;
  end

  // One enable candidate per divide code: low k bits of the counter all zero.
  for (genvar k = 0; k < NUM_CODE; k++) begin : g_cand
    localparam logic [OSC_W-1:0] LOW_MASK = (OSC_W'(1) << k) - OSC_W'(1);
    assign candEn[k] = ((oscCnt & LOW_MASK) == '0);
  end

  assign sysClkEn = candEn[activeDiv];

  // Timer prescaler: reloading down counter advanced by the system enable.
  always_ff @(posedge clk) begin
    if (!rstN)                    prescCnt <= '0;
    else if (strobes.prescReload) prescCnt <= loadPresc;
    else if (sysClkEn) begin
      if (prescCnt == '0)         prescCnt <= prescField;
      else                        prescCnt <= prescCnt - 1'b1;
    end
  end

  assign timerTick = sysClkEn && (prescCnt == '0);

  // Clock output: toggles on each system enable, forced low when disabled.
  always_ff @(posedge clk) begin
    if (!rstN)          clkOutQ <= 1'b0;
    else if (!outEnable) clkOutQ <= 1'b0;
    else if (sysClkEn)  clkOutQ <= ~clkOutQ;
  end

  assign clkOut = clkOutQ;

  // R4
  div_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN && $past(rstN) && (activeDiv != $past(activeDiv)) |-> $past(oscCnt) == {OSC_W{1'b1}});

  // R5
  tick_in_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerTick |-> sysClkEn);

  // R5
  presc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    prescCnt <= prescField);

  // R7
  clkout_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnable && sysClkEn |=> clkOut != $past(clkOut));

  // R8
  clkout_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |=> !clkOut);

endmodule

// File: rtl/clk_ctl_top.sv
module clk_ctl_top
  import clk_ctl_pkg::*;
#(
  parameter int OSC_W = 7,
  parameter int DIV_W = 3,
  parameter int PSC_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [PSC_W+DIV_W:0]      wrData,
  output logic [PSC_W+DIV_W:0]      rdData,
  output logic                      sysClkEn,
  output logic                      timerTick,
  output logic                      clkOut
);

  localparam int REG_W   = PSC_W + DIV_W + 1;
  localparam int PSC_LSB = DIV_W + 1;

  logic [REG_W-1:0] ctrlReg;
  logic [OSC_W-1:0] oscCnt;
  logic [PSC_W-1:0] loadPresc;
  ctlStrobes_t      strobes;

  clk_ctl_ctrl #(.OSC_W(OSC_W), .DIV_W(DIV_W), .PSC_W(PSC_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .ctrlReg   (ctrlReg),
    .oscCnt    (oscCnt),
    .loadPresc (loadPresc),
    .strobes   (strobes)
  );

  clk_ctl_dp #(.OSC_W(OSC_W), .DIV_W(DIV_W), .PSC_W(PSC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .oscCnt     (oscCnt),
    .divField   (ctrlReg[DIV_W:1]),
    .prescField (ctrlReg[REG_W-1:PSC_LSB]),
    .loadPresc  (loadPresc),
    .outEnable  (ctrlReg[0]),
    .sysClkEn   (sysClkEn),
    .timerTick  (timerTick),
    .clkOut     (clkOut)
  );

  assign rdData = ctrlReg;

endmodule

// File: tb/tb_clk_ctl_top.sv
module tb_clk_ctl_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       sysClkEn, timerTick, clkOut;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  clk_ctl_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .sysClkEn(sysClkEn), .timerTick(timerTick), .clkOut(clkOut)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic nextPulse(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sysClkEn);
  endtask

  task automatic nextTick(output int oscGap, output int enGap, output int orphan);
    oscGap = 0; enGap = 0; orphan = 0;
    do begin
      @(negedge clk); oscGap++;
      if (sysClkEn) enGap++;
      if (timerTick && !sysClkEn) orphan++;
    end while (!timerTick);
  endtask

  task automatic runLen(input logic lvl, output int n);
    while (clkOut == lvl) @(negedge clk);
    while (clkOut != lvl) @(negedge clk);
    n = 0;
    while (clkOut == lvl) begin @(negedge clk); n++; end
  endtask

  task automatic testReset();
    int badEn = 0, badTick = 0, badOut = 0;
    idle(3);
    rstN = 1'b1;
    check("R1", "rdData after reset", rdData, 0);
    for (int i = 0; i < 6; i++) begin
      if (!sysClkEn) badEn++;
      if (!timerTick) badTick++;
      if (clkOut) badOut++;
      @(negedge clk);
    end
    check("R1", "cycles without enable", badEn, 0);
    check("R1", "cycles without tick", badTick, 0);
    check("R1", "cycles with clkOut high", badOut, 0);
  endtask

  task automatic testReadback();
    writeReg(8'hA4);
    check("R2", "readback A4", rdData, 8'hA4);
    writeReg(8'h3C);
    check("R2", "readback 3C", rdData, 8'h3C);
    idle(4);
    check("R2", "value held without write", rdData, 8'h3C);
    writeReg(8'h00);
    check("R2", "readback 00", rdData, 0);
  endtask

  task automatic testDivCodes();
    int g;
    for (int k = 0; k < 8; k++) begin
      int bad = 0;
      writeReg(8'(k << 1));
      idle(130);
      nextPulse(g);
      @(negedge clk);
      check("R3", $sformatf("enable width code %0d", k), int'(sysClkEn), (k == 0) ? 1 : 0);
      nextPulse(g);
      for (int j = 0; j < 3; j++) begin
        nextPulse(g);
        if (g != (1 << k)) bad++;
      end
      check("R3", $sformatf("bad periods code %0d", k), bad, 0);
    end
  endtask

  task automatic divSwitch(input int a, input int b);
    int g, start, elapsed, oldP, newP, badMix, badNew, newSeen;
    oldP = 1 << a; newP = 1 << b;
    writeReg(8'(a << 1));
    idle(260);
    writeReg(8'(b << 1));
    elapsed = 0; badMix = 0; badNew = 0; newSeen = 0;
    nextPulse(g);
    elapsed += g;
    while (elapsed < 128 + 4 * newP) begin
      start = elapsed;
      nextPulse(g);
      elapsed += g;
      if (start >= 128) begin
        if (g != newP) badNew++;
        else newSeen++;
      end else if (g != oldP && g != newP) badMix++;
    end
    check("R4", $sformatf("intermediate gaps %0d->%0d", a, b), badMix, 0);
    check("R4", $sformatf("late gaps %0d->%0d", a, b), badNew, 0);
    check("R4", $sformatf("new-rate gaps seen %0d->%0d", a, b), int'(newSeen > 0), 1);
  endtask

  task automatic testDivChange();
    divSwitch(1, 5);
    divSwitch(6, 2);
    divSwitch(3, 0);
  endtask

  task automatic testPrescaler();
    int o, e, orph;
    writeReg(8'hB0);
    nextTick(o, e, orph);
    nextTick(o, e, orph);
    check("R5", "enables per tick, value 11", e, 12);
    check("R5", "tick without enable", orph, 0);
    writeReg(8'h34);
    idle(130);
    nextTick(o, e, orph);
    nextTick(o, e, orph);
    check("R5", "enables per tick, value 3", e, 4);
    check("R5", "osc cycles per tick, value 3 div 4", o, 16);
    writeReg(8'h00);
    idle(130);
    nextTick(o, e, orph);
    check("R5", "osc cycles per tick, value 0", o, 1);
  endtask

  task automatic testReload();
    int o, e, orph;
    writeReg(8'hF0);
    idle(5);
    writeReg(8'h20);
    check("R6", "tick right after reload", int'(timerTick), 0);
    nextTick(o, e, orph);
    check("R6", "cycles to first tick after reload", o, 2);
    nextTick(o, e, orph);
    check("R6", "steady ratio after reload", e, 3);
  endtask

  task automatic testClkOut();
    int n, bad, enSeen;
    writeReg(8'h03);
    idle(130);
    runLen(1'b1, n);
    check("R7", "high phase div 2", n, 2);
    runLen(1'b0, n);
    check("R7", "low phase div 2", n, 2);
    writeReg(8'h07);
    idle(130);
    runLen(1'b1, n);
    check("R7", "high phase div 8", n, 8);
    runLen(1'b0, n);
    check("R7", "low phase div 8", n, 8);
    writeReg(8'h06);
    @(negedge clk);
    bad = 0; enSeen = 0;
    for (int i = 0; i < 40; i++) begin
      if (clkOut) bad++;
      if (sysClkEn) enSeen++;
      @(negedge clk);
    end
    check("R8", "clkOut high while disabled", bad, 0);
    check("R8", "enables during disabled window", enSeen, 5);
  endtask

  initial begin
    testReset();
    testReadback();
    testDivCodes();
    testDivChange();
    testPrescaler();
    testReload();
    testClkOut();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule